// File: doc/BRIEF.md
# Slow-Clock Seconds Counter with Alarm

This block keeps wall-clock time in an always-on power domain. A 47-bit count advances once per edge of a slow 32 kHz clock. Bits 46..15 form a 32-bit whole-seconds value, and bits 14..0 count ticks within the second. Software runs on a fast bus clock and reaches the block through a small memory-mapped register port. From that port it can start or stop the count, load a new time while the count is stopped, program an alarm in seconds, and enable the alarm and the wakeup interrupt.

Every control bit is held in the bus domain and passes through two-flop synchronisers into the slow domain. A control change therefore becomes active on the third slow-clock edge after the bus write. The run bit is also synchronised back to the bus domain. Software polls that returned bit until it shows the new state. Counter loads are carried across the boundary by toggle handshakes, and an alarm-flag clear is carried the same way.

The count itself is read straight from the slow domain, one 32-bit half at a time. A pair of reads taken while the count runs may therefore disagree, and software is expected to re-read until two samples agree. A write-only key register records whether the last value written to it matched a fixed key.

Top module: `lpc_seconds_timer`

## Requirements
- R1: After reset, all readable registers read 0, the count is 0 and `alarm_irq` is 0.
- R2: While the synchronised run state is 0, the count holds its value from one slow edge to the next.
- R3: While running, the 47-bit count rises by exactly 1 on every slow edge. Ticks carry from bit 14 into the seconds field at bits 46..15.
- R4: While stopped, a write to offset 0x0C loads count bits 31..0, and a write to offset 0x08 loads count bits 46..32 from data bits 14..0. Each load is visible in the count on the third slow edge after the write.
- R5: A write to either count register is ignored if the control run bit is 1 or the returned run state is 1.
- R6: The control register is at offset 0x00, with bit 0 for run, bit 1 for alarm enable and bit 2 for wakeup enable. Bits 1 and 2 read back as written. Bit 0 reads the run state synchronised back from the slow domain, so right after a write it still shows the old value.
- R7: The alarm register is at offset 0x10. Status bit 0 (offset 0x04) is set on a slow edge where alarm enable is active and the count's seconds field equals the alarm register. It is never set while alarm enable is off.
- R8: Status bit 0 is sticky. Writing 1 to it clears it on the third slow edge after the write. If the alarm match is still true on that edge, the set wins and the bit stays 1.
- R9: `alarm_irq` is 1 only while the alarm flag is set and wakeup enable is active. It stays high until the flag is cleared.
- R10: A write to the key register at offset 0x14 sets status bit 1 if the data equals 0x41736166 and clears it otherwise. The key register itself always reads 0.
- R11: A change to the run, alarm-enable or wakeup-enable bit takes effect in the slow domain on the third slow edge after the bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast register-port clock |
| clk_slow | input | 1 | 32 kHz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| alarm_irq | output | 1 | Alarm interrupt and wakeup request, slow-domain register |

## Verification
On every slow edge, the assertions check three things: the count holds while stopped, the count steps by exactly one while running, and the alarm flag obeys its set, sticky and clear rules. In the bus domain they check that count writes during running leave the staged value and its handshake untouched. Other behaviour can only be shown by the bench scenarios. These are the exact three-edge latency of the run and wakeup crossings, the carry from ticks into seconds, set winning over clear while the match holds, the returned run bit lagging a control write, and the key comparison. The bench shows these by sampling the count on every slow cycle against a stepping model at chosen moments.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // Register byte offsets on the bus port
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_CNTHI = 8'h08;
  localparam logic [7:0] OFF_CNTLO = 8'h0C;
  localparam logic [7:0] OFF_ALARM = 8'h10;
  localparam logic [7:0] OFF_KEY   = 8'h14;

  // Control bit positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_ALARM = 1;
  localparam int CTL_WAKE  = 2;

  // Status bit positions
  localparam int ST_FLAG = 0;
  localparam int ST_KEY  = 1;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_STAT,
    RS_CNTHI,
    RS_CNTLO,
    RS_ALARM,
    RS_KEY
  } reg_sel_e;

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpc_bus_regs.sv
module lpc_bus_regs
  import lpc_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          SEC_W  = 32,
  parameter int          CNT_W  = 47,
  parameter logic [31:0] KEY    = 32'h4173_6166,
  localparam int         HI_W   = CNT_W - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              run_rb,
  input  logic              flag_rb,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic              ctl_run,
  output logic              ctl_alarm,
  output logic              ctl_wake,
  output logic [SEC_W-1:0]  alarm_sec,
  output logic [31:0]       shadow_lo,
  output logic [HI_W-1:0]   shadow_hi,
  output logic              ld_lo_tgl,
  output logic              ld_hi_tgl,
  output logic              clr_tgl
);

  reg_sel_e rsel;
  logic     key_ok;
  logic     wr_hit;
  logic     cnt_wr_ok;

  always_comb begin
    rsel = RS_NONE;
    if      (addr == ADDR_W'(OFF_CTRL))  rsel = RS_CTRL;
    else if (addr == ADDR_W'(OFF_STAT))  rsel = RS_STAT;
    else if (addr == ADDR_W'(OFF_CNTHI)) rsel = RS_CNTHI;
    else if (addr == ADDR_W'(OFF_CNTLO)) rsel = RS_CNTLO;
    else if (addr == ADDR_W'(OFF_ALARM)) rsel = RS_ALARM;
    else if (addr == ADDR_W'(OFF_KEY))   rsel = RS_KEY;
  end

  assign wr_hit    = sel && wr;
  // Count loads only when fully stopped on both sides of the crossing
  assign cnt_wr_ok = !ctl_run && !run_rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_run   <= 1'b0;
      ctl_alarm <= 1'b0;
      ctl_wake  <= 1'b0;
      alarm_sec <= '0;
      shadow_lo <= '0;
      shadow_hi <= '0;
      ld_lo_tgl <= 1'b0;
      ld_hi_tgl <= 1'b0;
      clr_tgl   <= 1'b0;
      key_ok    <= 1'b0;
    end else if (wr_hit) begin
      unique case (rsel)
        RS_CTRL: begin
          ctl_run   <= wdata[CTL_RUN];
          ctl_alarm <= wdata[CTL_ALARM];
          ctl_wake  <= wdata[CTL_WAKE];
        end
        RS_STAT: if (wdata[ST_FLAG]) clr_tgl <= ~clr_tgl;
        RS_CNTHI: if (cnt_wr_ok) begin
          shadow_hi <= wdata[HI_W-1:0];
          ld_hi_tgl <= ~ld_hi_tgl;
        end
        RS_CNTLO: if (cnt_wr_ok) begin
          shadow_lo <= wdata;
          ld_lo_tgl <= ~ld_lo_tgl;
        end
        RS_ALARM: alarm_sec <= wdata[SEC_W-1:0];
        RS_KEY:   key_ok    <= (wdata == KEY);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (rsel)
        RS_CTRL: begin
          rdata[CTL_RUN]   = run_rb;
          rdata[CTL_ALARM] = ctl_alarm;
          rdata[CTL_WAKE]  = ctl_wake;
        end
        RS_STAT: begin
          rdata[ST_FLAG] = flag_rb;
          rdata[ST_KEY]  = key_ok;
        end
        RS_CNTHI: rdata[HI_W-1:0]  = cnt_live[CNT_W-1:32];
        RS_CNTLO: rdata            = cnt_live[31:0];
        RS_ALARM: rdata[SEC_W-1:0] = alarm_sec;
        default: ;
      endcase
    end
  end

  // R5: count writes during running leave staging and handshake untouched
  a_r5_lo_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rsel == RS_CNTLO && (ctl_run || run_rb))
      |=> ($stable(shadow_lo) && $stable(ld_lo_tgl)));

  a_r5_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rsel == RS_CNTHI && (ctl_run || run_rb))
      |=> ($stable(shadow_hi) && $stable(ld_hi_tgl)));

endmodule

// File: rtl/lpc_slow_core.sv
module lpc_slow_core #(
  parameter int  SUB_W = 15,
  parameter int  SEC_W = 32,
  localparam int CNT_W = SUB_W + SEC_W,
  localparam int HI_W  = CNT_W - 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_s,
  input  logic             alarm_en_s,
  input  logic             wake_s,
  input  logic             ld_lo_tgl_s,
  input  logic             ld_hi_tgl_s,
  input  logic             clr_tgl_s,
  input  logic [31:0]      shadow_lo,
  input  logic [HI_W-1:0]  shadow_hi,
  input  logic [SEC_W-1:0] alarm_sec,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q,
  output logic             irq_q
);

  function automatic logic [SEC_W-1:0] seconds_of(input logic [CNT_W-1:0] c);
    return c[CNT_W-1:SUB_W];
  endfunction

  function automatic logic [CNT_W-1:0] step_of(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  logic [2:0]       tgl_prev;
  logic             ld_lo, ld_hi, clr_pulse;
  logic             alarm_hit;
  logic [CNT_W-1:0] count_d;
  logic             flag_d;

  assign ld_lo     = ld_lo_tgl_s ^ tgl_prev[0];
  assign ld_hi     = ld_hi_tgl_s ^ tgl_prev[1];
  assign clr_pulse = clr_tgl_s   ^ tgl_prev[2];
  assign alarm_hit = alarm_en_s && (seconds_of(count_q) == alarm_sec);

  always_comb begin
    count_d = count_q;
    if (run_s) begin
      count_d = step_of(count_q);
    end else begin
      if (ld_lo) count_d[31:0]       = shadow_lo;
      if (ld_hi) count_d[CNT_W-1:32] = shadow_hi;
    end
  end

  // Set takes priority over a pending clear
  assign flag_d = alarm_hit || (flag_q && !clr_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev <= '0;
      count_q  <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      tgl_prev <= {clr_tgl_s, ld_hi_tgl_s, ld_lo_tgl_s};
      count_q  <= count_d;
      flag_q   <= flag_d;
      irq_q    <= flag_d && wake_s;
    end
  end

  // R2: stopped count holds unless a load arrives
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_s && !ld_lo && !ld_hi) |=> $stable(count_q));

  // R3: single-step increment while running
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_s |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R7: a match with alarm enabled sets the flag
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flag_q);

  // R7: no flag without a match
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !alarm_hit) |=> !flag_q);

  // R8: flag is sticky until a clear arrives
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_pulse) |=> flag_q);

  // R9: interrupt never without the flag
  a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);

endmodule

// File: rtl/lpc_seconds_timer.sv
module lpc_seconds_timer #(
  parameter int          ADDR_W      = 8,
  parameter int          SUB_W       = 15,
  parameter int          SEC_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] KEY         = 32'h4173_6166
) (
  input  logic              clk_bus,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_irq
);

  localparam int CNT_W = SUB_W + SEC_W;
  localparam int HI_W  = CNT_W - 32;

  logic             ctl_run, ctl_alarm, ctl_wake;
  logic [SEC_W-1:0] alarm_sec;
  logic [31:0]      shadow_lo;
  logic [HI_W-1:0]  shadow_hi;
  logic             ld_lo_tgl, ld_hi_tgl, clr_tgl;
  logic [5:0]       to_slow, in_slow;
  logic [1:0]       to_bus, in_bus;
  logic [CNT_W-1:0] count;
  logic             flag;

  assign to_slow = {clr_tgl, ld_hi_tgl, ld_lo_tgl, ctl_wake, ctl_alarm, ctl_run};

  lpc_sync #(.W(6), .STAGES(SYNC_STAGES)) i_sync_slow (
    .clk   (clk_slow),
    .rst_n (rst_n),
    .d     (to_slow),
    .q     (in_slow)
  );

  lpc_slow_core #(.SUB_W(SUB_W), .SEC_W(SEC_W)) i_core (
    .clk         (clk_slow),
    .rst_n       (rst_n),
    .run_s       (in_slow[0]),
    .alarm_en_s  (in_slow[1]),
    .wake_s      (in_slow[2]),
    .ld_lo_tgl_s (in_slow[3]),
    .ld_hi_tgl_s (in_slow[4]),
    .clr_tgl_s   (in_slow[5]),
    .shadow_lo   (shadow_lo),
    .shadow_hi   (shadow_hi),
    .alarm_sec   (alarm_sec),
    .count_q     (count),
    .flag_q      (flag),
    .irq_q       (alarm_irq)
  );

  assign to_bus = {flag, in_slow[0]};

  lpc_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync_bus (
    .clk   (clk_bus),
    .rst_n (rst_n),
    .d     (to_bus),
    .q     (in_bus)
  );

  lpc_bus_regs #(
    .ADDR_W (ADDR_W),
    .SEC_W  (SEC_W),
    .CNT_W  (CNT_W),
    .KEY    (KEY)
  ) i_regs (
    .clk       (clk_bus),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .run_rb    (in_bus[0]),
    .flag_rb   (in_bus[1]),
    .cnt_live  (count),
    .ctl_run   (ctl_run),
    .ctl_alarm (ctl_alarm),
    .ctl_wake  (ctl_wake),
    .alarm_sec (alarm_sec),
    .shadow_lo (shadow_lo),
    .shadow_hi (shadow_hi),
    .ld_lo_tgl (ld_lo_tgl),
    .ld_hi_tgl (ld_hi_tgl),
    .clr_tgl   (clr_tgl)
  );

endmodule

// File: tb/test_lpc_seconds_timer.sv
`timescale 1ns/1ps
module test_lpc_seconds_timer;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_HI = 8'h08,
                         A_LO = 8'h0C, A_ALRM = 8'h10, A_KEY = 8'h14;

  logic        clk_bus = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_bus = ~clk_bus;
  initial begin
    #5;
    forever #100 clk_slow = ~clk_slow;
  end

  lpc_seconds_timer i_lpc_seconds_timer (
    .clk_bus  (clk_bus),  .clk_slow (clk_slow), .rst_n (rst_n),
    .bus_sel  (bus_sel),  .bus_wr   (bus_wr),   .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),.bus_rdata(bus_rdata),.alarm_irq(alarm_irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic slow_edges(input int n);
    repeat (n) @(posedge clk_slow);
    @(negedge clk_bus);
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_read(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic poll_run(input bit want, input string req);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      bus_read(A_CTRL, v);
      if (v[0] == want) seen = 1;
    end
    check(seen, req, {63'd0, !want}, {63'd0, want});
  endtask

  // Behavioural model: count rises by one on every slow edge while running
  task automatic step_monitor(input int n, input string req, output logic [31:0] last);
    logic [31:0] model;
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_LO;
    @(negedge clk_slow); #1 model = bus_rdata;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_slow); #1;
      model = model + 32'd1;
      check(bus_rdata == model, req, bus_rdata, model);
    end
    last = model;
  endtask

  task automatic load_count(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] alarm);
    bus_write(A_LO, lo);
    bus_write(A_HI, hi);
    bus_write(A_ALRM, alarm);
    slow_edges(4);
  endtask

  initial begin
    logic [31:0] v, v0, last;
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_bus);

    // R1 reset state
    expect_reg(A_CTRL, 32'h0, "R1 ctrl");
    expect_reg(A_STAT, 32'h0, "R1 status");
    expect_reg(A_LO,   32'h0, "R1 count lo");
    expect_reg(A_HI,   32'h0, "R1 count hi");
    expect_reg(A_ALRM, 32'h0, "R1 alarm");
    check(alarm_irq == 1'b0, "R1 irq", alarm_irq, 0);

    // R2 stopped counter holds
    slow_edges(20);
    expect_reg(A_LO, 32'h0, "R2 hold after reset");

    // R4 loads while stopped, visible on third slow edge
    bus_write(A_LO, 32'h0002_FFF0);
    bus_write(A_HI, 32'h0000_0003);
    slow_edges(3);
    expect_reg(A_LO, 32'h0002_FFF0, "R4 lo load");
    expect_reg(A_HI, 32'h0000_0003, "R4 hi load");

    // R11/R6 start: readback lags, count steps on third edge
    bus_write(A_CTRL, 32'h1);
    expect_reg(A_CTRL, 32'h0, "R6 run readback lags");
    slow_edges(3);
    expect_reg(A_LO, 32'h0002_FFF1, "R11 run active on third edge");
    poll_run(1'b1, "R6 run readback");

    // R3 step every slow cycle across the second boundary
    step_monitor(40, "R3 step", last);
    check(last[31:15] == 17'd6, "R3 seconds carry", last[31:15], 6);
    expect_reg(A_HI, 32'h3, "R3 hi stable");

    // R5 writes ignored while running
    bus_read(A_LO, v0);
    bus_write(A_LO, 32'h0000_1234);
    bus_write(A_HI, 32'h0000_0007);
    bus_read(A_LO, v);
    check((v - v0) <= 32'd2, "R5 lo write ignored", v, v0);
    expect_reg(A_HI, 32'h3, "R5 hi write ignored");

    // R2 stop and hold
    bus_write(A_CTRL, 32'h0);
    poll_run(1'b0, "R6 stop readback");
    bus_read(A_LO, v0);
    slow_edges(10);
    expect_reg(A_LO, v0, "R2 hold after stop");

    // R7/R9 alarm with wakeup: seconds 7 -> 8
    load_count(32'h0003_FFF8, 32'h0, 32'd8);
    expect_reg(A_ALRM, 32'd8, "R7 alarm readback");
    bus_write(A_CTRL, 32'h7);
    poll_run(1'b1, "R6 run for alarm");
    expect_reg(A_CTRL, 32'h7, "R6 ctrl readback");
    expect_reg(A_STAT, 32'h0, "R7 no flag before match");
    check(alarm_irq == 1'b0, "R9 no irq before match", alarm_irq, 0);
    slow_edges(20);
    expect_reg(A_STAT, 32'h1, "R7 flag on match");
    check(alarm_irq == 1'b1, "R9 irq on match", alarm_irq, 1);

    // R8 set beats clear while match holds
    bus_write(A_STAT, 32'h1);
    slow_edges(6);
    expect_reg(A_STAT, 32'h1, "R8 set wins");

    // R8 clear after alarm disabled, exact on third edge
    bus_write(A_CTRL, 32'h5);
    slow_edges(4);
    expect_reg(A_STAT, 32'h1, "R8 sticky after disable");
    bus_write(A_STAT, 32'h1);
    slow_edges(2);
    check(alarm_irq == 1'b1, "R8 not cleared before third edge", alarm_irq, 1);
    slow_edges(1);
    check(alarm_irq == 1'b0, "R8 irq drops with clear", alarm_irq, 0);
    repeat (3) @(negedge clk_bus);
    expect_reg(A_STAT, 32'h0, "R8 flag cleared");

    // R9 wakeup gating and its crossing latency
    bus_write(A_CTRL, 32'h0);
    poll_run(1'b0, "R6 stop 2");
    load_count(32'h0004_FFF8, 32'h0, 32'd10);
    bus_write(A_CTRL, 32'h3);
    poll_run(1'b1, "R6 run 2");
    slow_edges(20);
    expect_reg(A_STAT, 32'h1, "R7 flag without wake");
    check(alarm_irq == 1'b0, "R9 irq gated by wake", alarm_irq, 0);
    bus_write(A_CTRL, 32'h7);
    slow_edges(2);
    check(alarm_irq == 1'b0, "R11 wake not yet active", alarm_irq, 0);
    slow_edges(1);
    check(alarm_irq == 1'b1, "R11 wake active on third edge", alarm_irq, 1);
    bus_write(A_CTRL, 32'h5);
    slow_edges(4);
    bus_write(A_STAT, 32'h1);
    slow_edges(6);
    expect_reg(A_STAT, 32'h0, "R8 clear 2");

    // R7 no flag with alarm disabled
    bus_write(A_CTRL, 32'h0);
    poll_run(1'b0, "R6 stop 3");
    load_count(32'h0005_FFF8, 32'h0, 32'd12);
    bus_write(A_CTRL, 32'h5);
    poll_run(1'b1, "R6 run 3");
    slow_edges(25);
    expect_reg(A_STAT, 32'h0, "R7 no flag when disabled");
    check(alarm_irq == 1'b0, "R9 no irq when disabled", alarm_irq, 0);
    bus_read(A_LO, v);
    check(v[31:15] == 17'd12, "R3 passed the alarm second", v[31:15], 12);

    // R10 key register
    bus_write(A_KEY, 32'h1234_5678);
    expect_reg(A_STAT, 32'h0, "R10 wrong key");
    bus_write(A_KEY, 32'h4173_6166);
    expect_reg(A_STAT, 32'h2, "R10 right key");
    expect_reg(A_KEY, 32'h0, "R10 key reads zero");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule